// File: doc/BRIEF.md
# Configuration Port Controller with Key-Gated Access

This block is the configuration side of a legacy peripheral-controller chip. Host software reaches it through two byte-wide I/O locations. The index port sits at offset 0 and the data port at offset 1. Each access is a one-cycle write or read strobe. Access starts closed. The host opens it by writing the unlock key 0x87 to the index port on two index writes in a row. It closes it again by writing the lock key 0xAA to the index port.

While access is open, the host writes a register number to the index port and then reads or writes that register through the data port. The block itself holds these registers:

- a logical-device select register;
- read-only chip identification bytes, for the device, its revision and the manufacturer;
- no other local register below 0x30.

Register numbers 0x30 and above belong to the selected logical device. Accesses to them are passed outward on a simple register bus. That bus carries the logical-device number, the register number, a write and a read strobe, and the write and read data.

The access gate is a three-state machine:

- **LOCKED**: access is closed. An index write of 0x87 takes the transition *first_key* to HALF_KEY. Any other index write stays in LOCKED.
- **HALF_KEY**: one key has been seen. A second 0x87 takes *second_key* to OPEN. Any other index write takes *key_broken* back to LOCKED.
- **OPEN**: access is open. An index write of 0xAA takes *lock_key* to LOCKED. Any other index write is latched as the register number.

Data-port accesses never change the state.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset the block is LOCKED, dev_sel is 0x00 and io_rdata is 0xFF. OPEN is reached only by two consecutive index-port writes of 0x87.
- R2: In HALF_KEY, an index-port write of any value other than 0x87 returns the block to LOCKED, so one further 0x87 does not open access.
- R3: In OPEN, an index-port write of 0xAA returns the block to LOCKED. Data-port writes that follow have no effect on any register until the two-key sequence is repeated.
- R4: A read strobe loads io_rdata on the clock edge where it is sampled, and io_rdata holds that value until the next read. A read of either port while not OPEN returns 0xFF.
- R5: In OPEN, an index-port write (io_addr=0) other than 0xAA becomes the current register number. A read of the index port returns that number.
- R6: Register 0x07 is the logical-device select. It is readable and writable through the data port (io_addr=1), and its value drives dev_sel. Writing 0x06 selects the general-purpose I/O device.
- R7: The registers 0x20/0x21 hold the device ID (high byte, low byte): 0x0541 when VARIANT=0, 0x0909 when VARIANT=1. Register 0x22 holds the REVISION parameter (default 0x11). The registers 0x23/0x24 hold 0x19/0x34. Writes to 0x20 through 0x24 are ignored.
- R8: In OPEN, a data-port access with register number ≥ 0x30 drives dev_wr or dev_rd high in the same cycle, with dev_addr equal to the register number and dev_wdata equal to io_wdata. A read returns dev_rdata.
- R9: A data-port access to a register number below 0x30 raises neither dev_wr nor dev_rd. A read of a register number below 0x30 that is not listed above returns 0x00.
- R10: While not OPEN, dev_wr and dev_rd stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Registered host read byte |
| dev_sel | output | 8 | Current logical-device number |
| dev_wr | output | 1 | Device register write strobe |
| dev_rd | output | 1 | Device register read strobe |
| dev_addr | output | 8 | Device register number |
| dev_wdata | output | 8 | Device register write byte |
| dev_rdata | input | 8 | Device register read byte |

## Verification
The key sequence is tried three ways:

- a clean double key, which must open access;
- a key, a foreign index byte, then a key, which must stay closed and so tells a one-deep key memory from a counter that forgets nothing;
- data writes after the lock key, which must leave dev_sel untouched.

Register traffic covers the local logical-device select, every identification byte, an attempted write to an ID byte, an unassigned local index, and a device-range index. The device-range index shows whether the 0x30 boundary sends strobes outward or keeps them local. A behavioural model in the bench predicts every read byte, every device strobe and dev_sel on each clock.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_HALF_KEY = 2'd1,
        ST_OPEN     = 2'd2
    } gate_state_t;

    localparam int unsigned BYTE_W       = 8;
    localparam logic [7:0]  KEY_UNLOCK   = 8'h87;
    localparam logic [7:0]  KEY_LOCK     = 8'hAA;
    localparam logic [7:0]  REG_LDSEL    = 8'h07;
    localparam logic [7:0]  REG_DEVID_HI = 8'h20;
    localparam logic [7:0]  REG_DEVID_LO = 8'h21;
    localparam logic [7:0]  REG_REV      = 8'h22;
    localparam logic [7:0]  REG_MFG_HI   = 8'h23;
    localparam logic [7:0]  REG_MFG_LO   = 8'h24;
    localparam logic [7:0]  DEV_WINDOW   = 8'h30;
    localparam logic [15:0] MFG_ID       = 16'h1934;
    localparam logic [7:0]  CLOSED_BYTE  = 8'hFF;

endpackage

// File: rtl/cfg_gate_fsm.sv
module cfg_gate_fsm
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              unlocked,
    output logic              idx_load
);
    gate_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                ST_LOCKED:   state_d = (wbyte == KEY_UNLOCK) ? ST_HALF_KEY : ST_LOCKED;
                ST_HALF_KEY: state_d = (wbyte == KEY_UNLOCK) ? ST_OPEN : ST_LOCKED;
                ST_OPEN:     state_d = (wbyte == KEY_LOCK) ? ST_LOCKED : ST_OPEN;
                default:     state_d = ST_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        unlocked = 1'b0;
        idx_load = 1'b0;
        unique case (state_q)
            ST_LOCKED, ST_HALF_KEY: begin
                unlocked = 1'b0;
                idx_load = 1'b0;
            end
            ST_OPEN: begin
                unlocked = 1'b1;
                idx_load = idx_wr && (wbyte != KEY_LOCK);
            end
            default: begin
                unlocked = 1'b0;
                idx_load = 1'b0;
            end
        endcase
    end

    // R1: entering OPEN is always preceded by an unlock key write
    a_r1_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && $past(state_q) != ST_OPEN) |->
            ($past(idx_wr) && $past(wbyte) == KEY_UNLOCK && $past(state_q) == ST_HALF_KEY));

    // R2: a foreign index byte after one key drops back to locked
    a_r2_key_broken: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALF_KEY && idx_wr && wbyte != KEY_UNLOCK) |=> state_q == ST_LOCKED);

    // R3: lock key closes access
    a_r3_lock_key: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && idx_wr && wbyte == KEY_LOCK) |=> !unlocked);
endmodule

// File: rtl/cfg_id_rom.sv
module cfg_id_rom
    import cfgport_pkg::*;
#(
    parameter int unsigned VARIANT  = 0,
    parameter logic [7:0]  REVISION = 8'h11
) (
    input  logic [BYTE_W-1:0] reg_num,
    output logic              hit,
    output logic [BYTE_W-1:0] value
);
    logic [15:0] dev_id;

    generate
        if (VARIANT == 0) begin : g_var_a
            assign dev_id = 16'h0541;
        end else begin : g_var_b
            assign dev_id = 16'h0909;
        end
    endgenerate

    always_comb begin
        hit   = 1'b1;
        value = 8'h00;
        unique case (reg_num)
            REG_DEVID_HI: value = dev_id[15:8];
            REG_DEVID_LO: value = dev_id[7:0];
            REG_REV:      value = REVISION;
            REG_MFG_HI:   value = MFG_ID[15:8];
            REG_MFG_LO:   value = MFG_ID[7:0];
            default: begin
                hit   = 1'b0;
                value = 8'h00;
            end
        endcase
    end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfgport_pkg::*;
#(
    parameter int unsigned VARIANT  = 0,
    parameter logic [7:0]  REVISION = 8'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlocked,
    input  logic              idx_load,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [BYTE_W-1:0] io_rdata,
    output logic [BYTE_W-1:0] dev_sel,
    output logic              dev_wr,
    output logic              dev_rd,
    output logic [BYTE_W-1:0] dev_addr,
    output logic [BYTE_W-1:0] dev_wdata,
    input  logic [BYTE_W-1:0] dev_rdata
);
    logic [BYTE_W-1:0] index_q;
    logic [BYTE_W-1:0] ldsel_q;
    logic [BYTE_W-1:0] rom_val;
    logic              rom_hit;
    logic              in_window;
    logic              dat_wr_ok;
    logic              dat_rd_ok;
    logic [BYTE_W-1:0] read_val;

    cfg_id_rom #(.VARIANT(VARIANT), .REVISION(REVISION)) u_rom (
        .reg_num (index_q),
        .hit     (rom_hit),
        .value   (rom_val)
    );

    assign in_window = (index_q >= DEV_WINDOW);
    assign dat_wr_ok = unlocked && io_wr && io_addr;
    assign dat_rd_ok = unlocked && io_rd && io_addr;

    assign dev_wr    = dat_wr_ok && in_window;
    assign dev_rd    = dat_rd_ok && in_window;
    assign dev_addr  = index_q;
    assign dev_wdata = io_wdata;
    assign dev_sel   = ldsel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= 8'h00;
            ldsel_q <= 8'h00;
        end else begin
            if (idx_load)
                index_q <= io_wdata;
            if (dat_wr_ok && index_q == REG_LDSEL)
                ldsel_q <= io_wdata;
        end
    end

    always_comb begin
        if (!unlocked)
            read_val = CLOSED_BYTE;
        else if (!io_addr)
            read_val = index_q;
        else if (in_window)
            read_val = dev_rdata;
        else if (index_q == REG_LDSEL)
            read_val = ldsel_q;
        else if (rom_hit)
            read_val = rom_val;
        else
            read_val = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     io_rdata <= CLOSED_BYTE;
        else if (io_rd) io_rdata <= read_val;
    end

    // R6: select register changes only on an open data write to 0x07
    a_r6_ldsel_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlocked && io_wr && io_addr && index_q == REG_LDSEL) |=> $stable(ldsel_q));

    // R4: a closed read yields the closed byte
    a_r4_closed_read: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !unlocked) |=> io_rdata == CLOSED_BYTE);
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter int unsigned VARIANT  = 0,
    parameter logic [7:0]  REVISION = 8'h11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic       io_addr,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    output logic [7:0] dev_sel,
    output logic       dev_wr,
    output logic       dev_rd,
    output logic [7:0] dev_addr,
    output logic [7:0] dev_wdata,
    input  logic [7:0] dev_rdata
);
    logic unlocked;
    logic idx_load;

    cfg_gate_fsm u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && !io_addr),
        .wbyte    (io_wdata),
        .unlocked (unlocked),
        .idx_load (idx_load)
    );

    cfg_regs #(.VARIANT(VARIANT), .REVISION(REVISION)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .unlocked  (unlocked),
        .idx_load  (idx_load),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .dev_sel   (dev_sel),
        .dev_wr    (dev_wr),
        .dev_rd    (dev_rd),
        .dev_addr  (dev_addr),
        .dev_wdata (dev_wdata),
        .dev_rdata (dev_rdata)
    );

    // R10: no device strobes while closed
    a_r10_quiet_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> (!dev_wr && !dev_rd));
endmodule

// File: tb/sim_cfgport_ctrl.sv
module sim_cfgport_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr = 1'b0, io_rd = 1'b0, io_addr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata, dev_sel, dev_addr, dev_wdata, dev_rdata;
    logic       dev_wr, dev_rd;

    int checks = 0, fails = 0;
    int keys = 0;          // model: 0 locked, 1 half key, 2 open
    int m_idx = 0, m_ldsel = 0;
    bit model_live = 0;

    always #2.5 clk = ~clk;

    assign dev_rdata = dev_addr ^ 8'h5A;

    cfgport_ctrl u0 (.*);

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_read(bit a);
        if (keys != 2) return 8'hFF;
        if (!a) return m_idx;
        if (m_idx >= 8'h30) return m_idx ^ 8'h5A;
        case (m_idx)
            8'h07: return m_ldsel;
            8'h20: return 8'h05;
            8'h21: return 8'h41;
            8'h22: return 8'h11;
            8'h23: return 8'h19;
            8'h24: return 8'h34;
            default: return 0;
        endcase
    endfunction

    always @(negedge clk) if (model_live) check("R6 dev_sel", dev_sel, m_ldsel);

    task automatic idx_wr(string req, logic [7:0] b);
        @(negedge clk);
        io_wr = 1; io_addr = 0; io_wdata = b;
        #1 check({req, " idx strobes"}, {dev_wr, dev_rd}, 0);
        @(posedge clk);
        if (keys == 2) begin
            if (b == 8'hAA) keys = 0; else m_idx = b;
        end else if (b == 8'h87) keys = keys + 1;
        else keys = 0;
        @(negedge clk); io_wr = 0;
    endtask

    task automatic dat_wr(string req, logic [7:0] b);
        bit win;
        @(negedge clk);
        io_wr = 1; io_addr = 1; io_wdata = b;
        win = (keys == 2) && (m_idx >= 8'h30);
        #1 check({req, " dev_wr"}, dev_wr, win);
        if (win) begin
            check({req, " dev_addr"}, dev_addr, m_idx);
            check({req, " dev_wdata"}, dev_wdata, b);
        end
        @(posedge clk);
        if (keys == 2 && m_idx == 8'h07) m_ldsel = b;
        @(negedge clk); io_wr = 0;
    endtask

    task automatic rd(string req, bit a);
        int e;
        @(negedge clk);
        io_rd = 1; io_addr = a;
        e = exp_read(a);
        #1 check({req, " dev_rd"}, dev_rd, (keys == 2) && a && (m_idx >= 8'h30));
        @(posedge clk);
        @(negedge clk); io_rd = 0;
        check({req, " rdata"}, io_rdata, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_live = 1;
        check("R1 reset rdata", io_rdata, 8'hFF);
        rd("R4 closed data read", 1);
        rd("R4 closed index read", 0);
        idx_wr("R1", 8'h07);
        dat_wr("R10 closed write", 8'h06);
        idx_wr("R2", 8'h87);
        idx_wr("R2", 8'h12);
        idx_wr("R2", 8'h87);
        rd("R2 still closed", 1);
        idx_wr("R1", 8'h87);
        rd("R1 open after two keys", 0);
        for (int r = 8'h20; r <= 8'h24; r++) begin
            idx_wr("R7", 8'(r));
            rd("R7 id byte", 1);
        end
        idx_wr("R7", 8'h21);
        dat_wr("R7 id write", 8'h55);
        rd("R7 id unchanged", 1);
        idx_wr("R6", 8'h07);
        dat_wr("R6 select gpio", 8'h06);
        rd("R6 readback", 1);
        idx_wr("R8", 8'h40);
        dat_wr("R8 window write", 8'h3C);
        rd("R8 window read", 1);
        idx_wr("R8", 8'h30);
        dat_wr("R8 window edge", 8'hC3);
        idx_wr("R9", 8'h2F);
        dat_wr("R9 below window", 8'h77);
        rd("R9 unassigned", 1);
        rd("R5 index read", 0);
        idx_wr("R3", 8'h07);
        idx_wr("R3", 8'hAA);
        dat_wr("R3 write after lock", 8'h09);
        rd("R3 closed read", 1);
        idx_wr("R3", 8'h87);
        idx_wr("R3", 8'h87);
        idx_wr("R3", 8'h07);
        rd("R3 select kept", 1);
        model_live = 0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule